// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects 32 external interrupt request lines and hands at most one interrupt at a time to a processor core. Each interrupt carries a vector that cannot be changed: line n always uses vector 32 + n. A larger vector has higher priority. Each line has a mask bit and a trigger-mode bit. The controller keeps a pending set and an in-service set, so a more urgent request can interrupt a handler that is already running.

The core sees `irqOut` together with `irqVector`. It takes the interrupt by raising `irqAck` for one cycle, and it retires the interrupt by writing the end-of-service register. That write also lets the next pending request through. A task-priority register can hold back whole priority classes. A local timer request can be steered onto any one of lines 0 to 15. Software uses a simple single-cycle register bus: writes are strobed, and reads are combinational from `regAddr`.

Top module: `vecIrqCtl`

## Requirements
- R1: After reset the line-mask register (address 0) reads all ones and the trigger register (address 1) reads zero. The pending register (address 2) and the in-service register (address 3) read zero. The task-priority register (address 5) reads zero. The timer routing register (address 6) reads 0x0001_0000, which means the timer is masked. `irqOut` is low.
- R2: When `irqOut` is high, `irqVector` equals 32 plus the number of the line being offered.
- R3: When several lines are eligible at once, the highest-numbered line is offered.
- R4: A cycle with `irqAck` high while `irqOut` is high sets the offered line's bit in the in-service register. For an edge line it also clears that line's pending bit.
- R5: A request on a line above the highest line in service is offered at once (preemption). A request on a line at or below it stays pending and is not offered.
- R6: A write to address 4 (end of service), whatever the data, clears the highest set bit of the in-service register. With no bit set, the write changes nothing.
- R7: After an end-of-service write, the highest eligible pending line above any line still in service is offered.
- R8: A line whose mask bit is 1 still becomes pending, as seen at address 2, but is never offered. Clearing the mask bit makes it eligible for delivery.
- R9: A line with trigger bit 0 (edge) latches pending on a rising edge only; holding the input high does not make it pending again. A line with trigger bit 1 (level) reads pending exactly while its input is high.
- R10: Bits 3:0 of address 6 pick the line that `timerReq` drives, and bit 16 masks the timer. A masked timer has no effect on any line.
- R11: Line n is offered only if bits 7:4 of its vector (32 + n) are greater than bits 7:4 of the task-priority register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 32 | External interrupt request lines |
| timerReq | input | 1 | Local timer request |
| irqOut | output | 1 | Interrupt offered to the core |
| irqVector | output | 8 | Vector of the offered interrupt |
| irqAck | input | 1 | Core takes the offered interrupt |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |

## Verification
A wrong bit in the pending or in-service set shows at the ports in the very next cycle. The symptoms are a missing or extra `irqOut`, a wrong `irqVector`, or a wrong value read back at address 2 or 3. The error then carries into every later delivery, because priority compares against the highest line in service. A stale in-service bit blocks lower lines indefinitely. A lost one lets a lower line preempt, and that shows up at the next request to arrive.

// File: rtl/vecIrqPkg.sv
package vecIrqPkg;
  localparam int VEC_W = 8;
  localparam logic [3:0] ADDR_MASK  = 4'd0;
  localparam logic [3:0] ADDR_TRIG  = 4'd1;
  localparam logic [3:0] ADDR_PEND  = 4'd2;
  localparam logic [3:0] ADDR_SERV  = 4'd3;
  localparam logic [3:0] ADDR_EOI   = 4'd4;
  localparam logic [3:0] ADDR_TPR   = 4'd5;
  localparam logic [3:0] ADDR_TIMER = 4'd6;
  localparam int TIMER_MASK_BIT = 16;

  typedef struct packed {
    logic wrMask;
    logic wrTrig;
    logic wrTpr;
    logic wrTimer;
    logic eoi;
    logic ack;
  } picStrobe_t;
endpackage

// File: rtl/vecIrqCtlCtrl.sv
module vecIrqCtlCtrl
  import vecIrqPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              irqAck,
  input  logic              irqOut,
  output picStrobe_t        strb
);
  always_comb begin
    strb = '0;
    if (regWrEn) begin
      unique case (regAddr)
        ADDR_MASK:  strb.wrMask  = 1'b1;
        ADDR_TRIG:  strb.wrTrig  = 1'b1;
        ADDR_EOI:   strb.eoi     = 1'b1;
        ADDR_TPR:   strb.wrTpr   = 1'b1;
        ADDR_TIMER: strb.wrTimer = 1'b1;
        default: ;
      endcase
    end
    strb.ack = irqAck & irqOut;
  end
endmodule

// File: rtl/vecIrqCtlPath.sv
module vecIrqCtlPath
  import vecIrqPkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int VEC_BASE  = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int SEL_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic                 timerReq,
  input  picStrobe_t           strb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic                 irqOut,
  output logic [VEC_W-1:0]     irqVector,
  output logic [DATA_W-1:0]    rdData
);
  localparam int LINE_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] maskReg, trigLevel, pendEdge, inServ, prevReq;
  logic [NUM_LINES-1:0] lineReq, timerVec, rise, pendEff, tprOk, eligible;
  logic [NUM_LINES-1:0] ackOh, eoiOh;
  logic [7:0]           tprReg;
  logic [SEL_W-1:0]     timerSel;
  logic                 timerMasked;
  logic [LINE_W-1:0]    topLine, svcLine;
  logic                 anyElig, anyServ;

  function automatic logic [LINE_W-1:0] msbIdx(input logic [NUM_LINES-1:0] v);
    msbIdx = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (v[i]) msbIdx = LINE_W'(i);
  endfunction

  // per-line timer routing and task-priority class gate
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    localparam logic [VEC_W-1:0] VEC_G = VEC_W'(VEC_BASE + g);
    assign timerVec[g] = timerReq && !timerMasked && (int'(timerSel) == g);
    assign tprOk[g]    = VEC_G[7:4] > tprReg[7:4];
  end

  assign lineReq  = reqIn | timerVec;
  assign rise     = lineReq & ~prevReq;
  assign pendEff  = (pendEdge & ~trigLevel) | (lineReq & trigLevel);
  assign eligible = pendEff & ~maskReg & tprOk;
  assign anyElig  = |eligible;
  assign anyServ  = |inServ;
  assign topLine  = msbIdx(eligible);
  assign svcLine  = msbIdx(inServ);

  assign irqOut    = anyElig && (!anyServ || topLine > svcLine);
  assign irqVector = VEC_W'(VEC_BASE) + VEC_W'(topLine);

  assign ackOh = strb.ack ? (NUM_LINES'(1) << topLine) : '0;
  assign eoiOh = (strb.eoi && anyServ) ? (NUM_LINES'(1) << svcLine) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg     <= '1;
      trigLevel   <= '0;
      pendEdge    <= '0;
      inServ      <= '0;
      prevReq     <= '0;
      tprReg      <= '0;
      timerSel    <= '0;
      timerMasked <= 1'b1;
    end else begin
      prevReq  <= lineReq;
      pendEdge <= ((pendEdge & ~ackOh) | rise) & ~trigLevel;
      inServ   <= (inServ & ~eoiOh) | ackOh;
      if (strb.wrMask) maskReg   <= wrData[NUM_LINES-1:0];
      if (strb.wrTrig) trigLevel <= wrData[NUM_LINES-1:0];
      if (strb.wrTpr)  tprReg    <= wrData[7:0];
      if (strb.wrTimer) begin
        timerSel    <= wrData[SEL_W-1:0];
        timerMasked <= wrData[TIMER_MASK_BIT];
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_MASK:  rdData[NUM_LINES-1:0] = maskReg;
      ADDR_TRIG:  rdData[NUM_LINES-1:0] = trigLevel;
      ADDR_PEND:  rdData[NUM_LINES-1:0] = pendEff;
      ADDR_SERV:  rdData[NUM_LINES-1:0] = inServ;
      ADDR_TPR:   rdData[7:0]           = tprReg;
      ADDR_TIMER: begin
        rdData[SEL_W-1:0]      = timerSel;
        rdData[TIMER_MASK_BIT] = timerMasked;
      end
      default: ;
    endcase
  end

  // R2: an offered vector lies inside the fixed window
  a_r2_vector_window: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqVector >= VEC_W'(VEC_BASE) && irqVector < VEC_W'(VEC_BASE + NUM_LINES)));
  // R4: acknowledged line is in service next cycle
  a_r4_ack_to_service: assert property (@(posedge clk) disable iff (!rstN)
    strb.ack |=> inServ[$past(topLine)]);
  // R6: end of service retires the top in-service line
  a_r6_eoi_retires: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoi && anyServ && !strb.ack) |=> !inServ[$past(svcLine)]);
  // R6: end of service with nothing in service changes nothing
  a_r6_eoi_idle: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoi && !anyServ && !strb.ack) |=> (inServ == '0));
  // R9: a rising edge on an edge line is latched as pending
  a_r9_edge_latch: assert property (@(posedge clk) disable iff (!rstN)
    |(rise & ~trigLevel & ~ackOh) |=> ((pendEdge & $past(rise & ~trigLevel & ~ackOh))
                                      == $past(rise & ~trigLevel & ~ackOh)));
endmodule

// File: rtl/vecIrqCtl.sv
module vecIrqCtl
  import vecIrqPkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int VEC_BASE  = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int SEL_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic                 timerReq,
  output logic                 irqOut,
  output logic [VEC_W-1:0]     irqVector,
  input  logic                 irqAck,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData
);
  picStrobe_t strb;

  vecIrqCtlCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .irqAck(irqAck),
    .irqOut(irqOut), .strb(strb)
  );

  vecIrqCtlPath #(
    .NUM_LINES(NUM_LINES), .VEC_BASE(VEC_BASE), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .timerReq(timerReq),
    .strb(strb), .wrData(regWrData), .rdAddr(regAddr),
    .irqOut(irqOut), .irqVector(irqVector), .rdData(regRdData)
  );
endmodule

// File: tb/vecIrqCtl_test.sv
`timescale 1ns/100ps
module vecIrqCtl_test;
  logic        clk = 1'b0, rstN = 1'b0;
  logic [31:0] reqIn = '0;
  logic        timerReq = 1'b0, irqAck = 1'b0, regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        irqOut;
  logic [7:0]  irqVector;
  int checks = 0, fails = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  vecIrqCtl uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .timerReq(timerReq),
    .irqOut(irqOut), .irqVector(irqVector), .irqAck(irqAck),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkIrq(input string tag, input bit on, input int line);
    chk({tag, " irqOut"}, 32'(irqOut), 32'(on));
    if (on) chk({tag, " vector"}, 32'(irqVector), 32'(32 + line));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d; tick(); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic ack();
    irqAck = 1'b1; tick(); irqAck = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] m);
    reqIn = m; tick(); reqIn = '0;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) tick();
    rstN = 1'b1; tick();
    // R1 reset state
    rd(4'd0, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(4'd1, d); chk("R1 trig", d, 32'h0);
    rd(4'd2, d); chk("R1 pend", d, 32'h0);
    rd(4'd3, d); chk("R1 inserv", d, 32'h0);
    rd(4'd5, d); chk("R1 tpr", d, 32'h0);
    rd(4'd6, d); chk("R1 timer", d, 32'h0001_0000);
    chk("R1 irqOut", 32'(irqOut), 32'h0);

    // R6 end of service with nothing in service
    wr(4'd4, 32'h1234_5678);
    rd(4'd3, d); chk("R6 idle eoi", d, 32'h0);

    // R8 masked line pends but is not offered
    wr(4'd0, 32'h0000_1000);
    pulse(32'h0000_1000); tick();
    chkIrq("R8 masked", 0, 0);
    rd(4'd2, d); chk("R8 pend visible", d, 32'h0000_1000);
    wr(4'd0, 32'h0);
    chkIrq("R8 unmasked", 1, 12);
    ack(); wr(4'd4, 32'h0);

    // R2 R4 single-line sweep
    for (int n = 0; n < 32; n++) begin
      pulse(32'(1) << n);
      chkIrq("R2 single", 1, n);
      ack();
      rd(4'd3, d); chk("R4 inserv", d, 32'(1) << n);
      rd(4'd2, d); chk("R4 pend cleared", d, 32'h0);
      wr(4'd4, 32'hDEAD_0000 ^ 32'(n));
      rd(4'd3, d); chk("R6 retired", d, 32'h0);
    end

    // R3 R5 R7 pair sweep
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        int hi, lo;
        if (a == b) continue;
        hi = (a > b) ? a : b; lo = (a > b) ? b : a;
        pulse((32'(1) << a) | (32'(1) << b));
        chkIrq("R3 highest", 1, hi);
        ack();
        chkIrq("R5 lower held", 0, 0);
        wr(4'd4, 32'(a));
        chkIrq("R7 next pending", 1, lo);
        ack(); wr(4'd4, 32'(b));
        // preemption
        pulse(32'(1) << lo); ack();
        pulse(32'(1) << hi);
        chkIrq("R5 preempt", 1, hi);
        ack();
        rd(4'd3, d); chk("R5 nested", d, (32'(1) << hi) | (32'(1) << lo));
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd3, d); chk("R6 top cleared", d, 32'(1) << lo);
        wr(4'd4, 32'h0);
        rd(4'd3, d); chk("R6 all cleared", d, 32'h0);
      end
    end

    // R9 edge line held high does not re-pend
    reqIn = 32'h80; tick();
    chkIrq("R9 edge", 1, 7);
    ack(); wr(4'd4, 32'h0); tick();
    chkIrq("R9 edge held", 0, 0);
    rd(4'd2, d); chk("R9 edge no repend", d, 32'h0);
    reqIn = '0; tick();

    // R9 level line follows its input
    wr(4'd1, 32'h20);
    reqIn = 32'h20; tick();
    chkIrq("R9 level", 1, 5);
    ack();
    chkIrq("R9 level in service", 0, 0);
    rd(4'd2, d); chk("R9 level pend", d, 32'h20);
    wr(4'd4, 32'h0);
    chkIrq("R9 level again", 1, 5);
    reqIn = '0; tick();
    chkIrq("R9 level dropped", 0, 0);
    rd(4'd2, d); chk("R9 level pend low", d, 32'h0);
    wr(4'd1, 32'h0);

    // R11 task priority classes
    wr(4'd5, 32'h20);
    pulse(32'h400); tick();
    chkIrq("R11 class blocked", 0, 0);
    pulse(32'h0010_0000);
    chkIrq("R11 class open", 1, 20);
    ack(); wr(4'd4, 32'h0);
    wr(4'd5, 32'h0);
    chkIrq("R11 released", 1, 10);
    ack(); wr(4'd4, 32'h0);
    wr(4'd5, 32'h30);
    pulse(32'h8000_0000); tick();
    chkIrq("R11 all blocked", 0, 0);
    wr(4'd5, 32'h0);
    chkIrq("R11 all released", 1, 31);
    ack(); wr(4'd4, 32'h0);

    // R10 timer routing
    wr(4'd6, 32'h9);
    timerReq = 1'b1; tick(); timerReq = 1'b0;
    chkIrq("R10 timer line 9", 1, 9);
    ack(); wr(4'd4, 32'h0);
    wr(4'd6, 32'hF);
    timerReq = 1'b1; tick(); timerReq = 1'b0;
    chkIrq("R10 timer line 15", 1, 15);
    ack(); wr(4'd4, 32'h0);
    wr(4'd6, 32'h0001_0009);
    timerReq = 1'b1; tick(); timerReq = 1'b0; tick();
    chkIrq("R10 timer masked", 0, 0);
    rd(4'd2, d); chk("R10 masked no pend", d, 32'h0);

    done = 1'b1;
    report();
  end
endmodule